// File: doc/BRIEF.md
# Dual Q15 Multiply-Accumulate Unit

This block accumulates dot products of packed fixed-point data. Each of its two 32-bit operand words carries a pair of signed 16-bit samples. For every accepted operation it multiplies the low halves together and the high halves together. It then either adds the two products or subtracts the high-half product from the low-half product, and adds that term to a running accumulator.

The accumulator can grow in a 32-bit two's-complement mode that wraps and raises a sticky overflow flag. It can also grow in a 64-bit mode that leaves headroom for long filter sums. A narrowing stage runs continuously on the accumulator. It takes the Q31-scaled value, shifts it right arithmetically by 15 and clamps it to a signed 16-bit Q15 sample.

A filter with N taps needs ceil(N/2) operations. When N is odd, the caller zeroes the unused half of the last word. Fetching samples and sequencing the loop are left to the surrounding logic.

Top module: `pq15_dual_mac`

## Requirements
- R1: Each operand word holds two signed two's-complement 16-bit values: the low half in bits 15:0 and the high half in bits 31:16.
- R2: With `diff_i`=0, an accepted operation adds (a_lo*b_lo + a_hi*b_hi) to the accumulator. Both products are full 32-bit signed values and are sign-extended before the sum, so a zero half contributes nothing.
- R3: With `diff_i`=1, an accepted operation adds (a_lo*b_lo - a_hi*b_hi) to the accumulator.
- R4: With `wide_i`=1, the 64-bit accumulator receives the sign-extended term without wrapping, and `ovf_o` is never set by that operation.
- R5: With `wide_i`=0, the new value is (acc_o[31:0] + term) wrapped to 32 bits and sign-extended onto `acc_o`. `ovf_o` is set when the exact sum lies outside [-2^31, 2^31-1].
- R6: `ovf_o` is sticky: once set, it stays high until a clear.
- R7: `q15_o` equals floor(acc_o / 2^15) clamped to [-32768, 32767]. It reads 0x7FFF above that range and 0x8000 below it.
- R8: `clear_i` zeroes the accumulator and `ovf_o` and drops `valid_o` at the next edge. It takes priority over a simultaneous `start_i`.
- R9: `valid_o` is high for exactly the one cycle after each accepted operation (`start_i`=1, `clear_i`=0). Without an operation, `acc_o` and `ovf_o` hold.
- R10: After reset, `acc_o`=0, `q15_o`=0, `valid_o`=0 and `ovf_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Accept one operation this cycle |
| clear_i | input | 1 | Zero the accumulator and the overflow flag |
| diff_i | input | 1 | 0: sum of products, 1: low product minus high product |
| wide_i | input | 1 | 0: 32-bit wrapping accumulate, 1: 64-bit accumulate |
| op_a_i | input | 32 | Packed operand A (two Q15 halves) |
| op_b_i | input | 32 | Packed operand B (two Q15 halves) |
| acc_o | output | 64 | Accumulator, sign-extended in 32-bit mode |
| q15_o | output | 16 | Accumulator shifted right by 15 and saturated |
| valid_o | output | 1 | Result of the last operation is present |
| ovf_o | output | 1 | Sticky 32-bit accumulation overflow |

## Verification
The bench builds the unit with its default parameters: 16-bit halves, two lanes, a 32-bit narrow and a 64-bit wide accumulator, and a shift of 15.

With these widths, a single operation on two pairs of -32768 produces exactly 2^31. That one value reaches the narrow overflow boundary, the wide-mode headroom and the positive clamp of the narrowing stage. Repeated difference terms near -2^30 drive the narrow accumulator through its negative wrap. Small mixed-sign operands check that the halves are placed correctly, that the shifted output rounds toward minus infinity, and that a zeroed half leaves the sum unchanged.

// File: rtl/pq15_mac_pkg.sv
package pq15_mac_pkg;
  typedef enum logic {COMB_SUM = 1'b0, COMB_DIFF = 1'b1} comb_e;
  typedef enum logic {ACC_NARROW = 1'b0, ACC_WIDE = 1'b1} acc_sel_e;
endpackage

// File: rtl/pq15_lane_mul.sv
module pq15_lane_mul #(
  parameter int HALF_W = 16,
  localparam int PROD_W = 2 * HALF_W
) (
  input  logic signed [HALF_W-1:0] a_i,
  input  logic signed [HALF_W-1:0] b_i,
  output logic signed [PROD_W-1:0] p_o
);
  assign p_o = a_i * b_i;
endmodule

// File: rtl/pq15_dot_combine.sv
module pq15_dot_combine
  import pq15_mac_pkg::*;
#(
  parameter int HALF_W = 16,
  parameter int LANES  = 2,
  parameter int TERM_W = 33,
  localparam int OP_W   = LANES * HALF_W,
  localparam int PROD_W = 2 * HALF_W
) (
  input  logic [OP_W-1:0]          a_i,
  input  logic [OP_W-1:0]          b_i,
  input  comb_e                    comb_i,
  output logic signed [TERM_W-1:0] term_o
);
  logic signed [PROD_W-1:0] prod [LANES];

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    pq15_lane_mul #(.HALF_W(HALF_W)) u_mul (
      .a_i(a_i[l*HALF_W +: HALF_W]),
      .b_i(b_i[l*HALF_W +: HALF_W]),
      .p_o(prod[l])
    );
  end

  // lane 0 is always added; the remaining lanes follow comb_i
  logic signed [TERM_W-1:0] ext_v;
  always_comb begin
    term_o = {{(TERM_W-PROD_W){prod[0][PROD_W-1]}}, prod[0]};
    ext_v  = '0;
    for (int l = 1; l < LANES; l++) begin
      ext_v  = {{(TERM_W-PROD_W){prod[l][PROD_W-1]}}, prod[l]};
      term_o = (comb_i == COMB_DIFF) ? term_o - ext_v : term_o + ext_v;
    end
  end
endmodule

// File: rtl/pq15_acc_stage.sv
module pq15_acc_stage
  import pq15_mac_pkg::*;
#(
  parameter int ACC_W    = 64,
  parameter int NARROW_W = 32,
  parameter int TERM_W   = 33,
  localparam int NSUM_W  = NARROW_W + 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     start_i,
  input  logic                     clear_i,
  input  acc_sel_e                 sel_i,
  input  logic signed [TERM_W-1:0] term_i,
  output logic [ACC_W-1:0]         acc_o,
  output logic                     ovf_o,
  output logic                     valid_o
);
  logic [ACC_W-1:0]  wide_sum;
  logic [NSUM_W-1:0] narrow_sum;
  logic [ACC_W-1:0]  narrow_ext;
  logic [2:0]        narrow_top;
  logic              narrow_ovf;

  assign wide_sum   = acc_o + {{(ACC_W-TERM_W){term_i[TERM_W-1]}}, term_i};
  // exact sum of the low NARROW_W bits and the term, with two guard bits
  assign narrow_sum = {{2{acc_o[NARROW_W-1]}}, acc_o[NARROW_W-1:0]}
                    + {{(NSUM_W-TERM_W){term_i[TERM_W-1]}}, term_i};
  assign narrow_top = narrow_sum[NSUM_W-1:NARROW_W-1];
  assign narrow_ovf = !((&narrow_top) || !(|narrow_top));
  assign narrow_ext = {{(ACC_W-NARROW_W){narrow_sum[NARROW_W-1]}},
                       narrow_sum[NARROW_W-1:0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_o   <= '0;
      ovf_o   <= 1'b0;
      valid_o <= 1'b0;
    end else if (clear_i) begin
      acc_o   <= '0;
      ovf_o   <= 1'b0;
      valid_o <= 1'b0;
    end else if (start_i) begin
      acc_o   <= (sel_i == ACC_WIDE) ? wide_sum : narrow_ext;
      ovf_o   <= ovf_o | ((sel_i == ACC_NARROW) & narrow_ovf);
      valid_o <= 1'b1;
    end else begin
      valid_o <= 1'b0;
    end
  end
endmodule

// File: rtl/pq15_narrow_sat.sv
module pq15_narrow_sat #(
  parameter int ACC_W = 64,
  parameter int SHIFT = 15,
  parameter int OUT_W = 16
) (
  input  logic [ACC_W-1:0] acc_i,
  output logic [OUT_W-1:0] q_o
);
  logic signed [ACC_W-1:0] shifted;
  logic [ACC_W-OUT_W:0]    upper;

  assign shifted = $signed(acc_i) >>> SHIFT;
  assign upper   = shifted[ACC_W-1:OUT_W-1];

  always_comb begin
    if ((&upper) || !(|upper)) q_o = shifted[OUT_W-1:0];
    else if (upper[ACC_W-OUT_W]) q_o = {1'b1, {(OUT_W-1){1'b0}}};
    else q_o = {1'b0, {(OUT_W-1){1'b1}}};
  end
endmodule

// File: rtl/pq15_dual_mac.sv
module pq15_dual_mac
  import pq15_mac_pkg::*;
#(
  parameter int HALF_W   = 16,
  parameter int LANES    = 2,
  parameter int NARROW_W = 32,
  parameter int ACC_W    = 64,
  parameter int Q_SHIFT  = 15,
  parameter int OUT_W    = 16,
  localparam int OP_W    = LANES * HALF_W,
  localparam int TERM_W  = 2 * HALF_W + $clog2(LANES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             clear_i,
  input  logic             diff_i,
  input  logic             wide_i,
  input  logic [OP_W-1:0]  op_a_i,
  input  logic [OP_W-1:0]  op_b_i,
  output logic [ACC_W-1:0] acc_o,
  output logic [OUT_W-1:0] q15_o,
  output logic             valid_o,
  output logic             ovf_o
);
  logic signed [TERM_W-1:0] term;

  pq15_dot_combine #(.HALF_W(HALF_W), .LANES(LANES), .TERM_W(TERM_W)) u_comb (
    .a_i   (op_a_i),
    .b_i   (op_b_i),
    .comb_i(comb_e'(diff_i)),
    .term_o(term)
  );

  pq15_acc_stage #(.ACC_W(ACC_W), .NARROW_W(NARROW_W), .TERM_W(TERM_W)) u_acc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_i),
    .clear_i(clear_i),
    .sel_i  (acc_sel_e'(wide_i)),
    .term_i (term),
    .acc_o  (acc_o),
    .ovf_o  (ovf_o),
    .valid_o(valid_o)
  );

  pq15_narrow_sat #(.ACC_W(ACC_W), .SHIFT(Q_SHIFT), .OUT_W(OUT_W)) u_sat (
    .acc_i(acc_o),
    .q_o  (q15_o)
  );
endmodule

// File: rtl/pq15_dual_mac_chk.sv
module pq15_dual_mac_chk #(
  parameter int ACC_W   = 64,
  parameter int OUT_W   = 16,
  parameter int Q_SHIFT = 15
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             clear_i,
  input logic             wide_i,
  input logic [ACC_W-1:0] acc_o,
  input logic [OUT_W-1:0] q15_o,
  input logic             valid_o,
  input logic             ovf_o
);
  localparam logic [ACC_W-1:0] POS_LIM = ACC_W'(1) << (OUT_W - 1 + Q_SHIFT);
  localparam logic [ACC_W-1:0] NEG_LIM = ~POS_LIM + ACC_W'(1);
  localparam logic [OUT_W-1:0] Q_MAX   = {1'b0, {(OUT_W-1){1'b1}}};
  localparam logic [OUT_W-1:0] Q_MIN   = {1'b1, {(OUT_W-1){1'b0}}};

  AST_VALID_AFTER_OP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !clear_i |=> valid_o); // R9
  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i && !clear_i |=> $stable(acc_o) && $stable(ovf_o) && !valid_o); // R9
  AST_CLEAR_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> acc_o == '0 && !ovf_o && !valid_o); // R8
  AST_OVF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o && !clear_i |=> ovf_o); // R6
  AST_WIDE_NO_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && wide_i && !clear_i && !ovf_o |=> !ovf_o); // R4
  AST_SAT_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $signed(acc_o) >= $signed(POS_LIM) |-> q15_o == Q_MAX); // R7
  AST_SAT_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $signed(acc_o) < $signed(NEG_LIM) |-> q15_o == Q_MIN); // R7
endmodule

bind pq15_dual_mac pq15_dual_mac_chk #(
  .ACC_W(ACC_W), .OUT_W(OUT_W), .Q_SHIFT(Q_SHIFT)
) u_chk (.*);

// File: tb/pq15_dual_mac_bench.sv
`timescale 1ns/1ps
module pq15_dual_mac_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, clear = 1'b0, diff = 1'b0, wide = 1'b0;
  logic [31:0] op_a = '0, op_b = '0;
  logic [63:0] acc;
  logic [15:0] q15;
  logic        valid, ovf;
  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  pq15_dual_mac u_pq15_dual_mac (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .clear_i(clear),
    .diff_i(diff), .wide_i(wide), .op_a_i(op_a), .op_b_i(op_b),
    .acc_o(acc), .q15_o(q15), .valid_o(valid), .ovf_o(ovf)
  );

  typedef struct packed {
    logic        clr;
    logic        dif;
    logic        wid;
    logic [31:0] a;
    logic [31:0] b;
    logic [63:0] e_acc;
    logic [15:0] e_q;
    logic        e_ovf;
  } vec_t;

  // R1 halves: hi=31:16, lo=15:0. R2 sum, R3 difference, R4 wide, R5 narrow
  localparam vec_t VECS [12] = '{
    '{1'b1, 1'b0, 1'b1, 32'h0003_0002, 32'h0005_0004, 64'h17, 16'h0000, 1'b0},
    '{1'b0, 1'b1, 1'b1, 32'h0003_0002, 32'h0005_0004, 64'h10, 16'h0000, 1'b0},
    '{1'b0, 1'b0, 1'b1, 32'hFFFF_0001, 32'h0002_0003, 64'h11, 16'h0000, 1'b0},
    '{1'b1, 1'b0, 1'b1, 32'h4000_4000, 32'h4000_4000, 64'h2000_0000, 16'h4000, 1'b0},
    '{1'b0, 1'b0, 1'b1, 32'h4000_4000, 32'h4000_4000, 64'h4000_0000, 16'h7FFF, 1'b0},
    '{1'b1, 1'b0, 1'b1, 32'h8000_8000, 32'h8000_8000, 64'h8000_0000, 16'h7FFF, 1'b0},
    '{1'b1, 1'b0, 1'b0, 32'h8000_8000, 32'h8000_8000, 64'hFFFF_FFFF_8000_0000, 16'h8000, 1'b1},
    '{1'b0, 1'b0, 1'b0, 32'h0000_0001, 32'h0000_0001, 64'hFFFF_FFFF_8000_0001, 16'h8000, 1'b1},
    '{1'b1, 1'b1, 1'b0, 32'h0001_8000, 32'h7FFF_7FFF, 64'hFFFF_FFFF_C000_0001, 16'h8000, 1'b0},
    '{1'b0, 1'b1, 1'b0, 32'h0001_8000, 32'h7FFF_7FFF, 64'hFFFF_FFFF_8000_0002, 16'h8000, 1'b0},
    '{1'b0, 1'b1, 1'b0, 32'h0001_8000, 32'h7FFF_7FFF, 64'h4000_0003, 16'h7FFF, 1'b1},
    '{1'b1, 1'b0, 1'b1, 32'h0000_0064, 32'h1234_FF9C, 64'hFFFF_FFFF_FFFF_D8F0, 16'hFFFF, 1'b0}
  };

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  task automatic do_clear();
    @(negedge clk); clear = 1'b1;
    @(negedge clk); clear = 1'b0;
  endtask

  task automatic do_op(input logic [31:0] a, input logic [31:0] b,
                       input logic d, input logic w);
    @(negedge clk);
    op_a = a; op_b = b; diff = d; wide = w; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  initial begin
    #800000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    // R10 reset state
    #20;
    check(acc == 64'h0 && q15 == 16'h0 && !valid && !ovf, "R10 reset",
          {q15, 13'h0, valid, ovf, acc[32:0]}, 64'h0);
    @(negedge clk); rst_n = 1'b1;

    foreach (VECS[i]) begin
      if (VECS[i].clr) do_clear();
      do_op(VECS[i].a, VECS[i].b, VECS[i].dif, VECS[i].wid);
      check(acc == VECS[i].e_acc, VECS[i].wid ? "R4 wide acc" : "R5 narrow acc",
            acc, VECS[i].e_acc);
      check(q15 == VECS[i].e_q, "R7 q15", {48'h0, q15}, {48'h0, VECS[i].e_q});
      check(ovf == VECS[i].e_ovf, "R6 ovf", {63'h0, ovf}, {63'h0, VECS[i].e_ovf});
      check(valid, "R9 valid after op", {63'h0, valid}, 64'h1);
    end

    // R9 idle cycles: valid drops, acc and ovf hold (last acc = -10000)
    repeat (3) @(negedge clk);
    check(!valid && acc == 64'hFFFF_FFFF_FFFF_D8F0 && !ovf, "R9 idle hold",
          acc, 64'hFFFF_FFFF_FFFF_D8F0);

    // R8 clear beats start, and clears a set overflow
    do_clear();
    do_op(32'h8000_8000, 32'h8000_8000, 1'b0, 1'b0);
    check(ovf, "R5 narrow overflow flag", {63'h0, ovf}, 64'h1);
    @(negedge clk);
    op_a = 32'h8000_8000; op_b = 32'h8000_8000; wide = 1'b1;
    clear = 1'b1; start = 1'b1;
    @(negedge clk);
    clear = 1'b0; start = 1'b0;
    check(acc == 64'h0 && !ovf && !valid, "R8 clear priority",
          {acc[61:0], ovf, valid}, 64'h0);

    // R4 long wide accumulation of 2^31 four times, no flag
    for (int k = 0; k < 4; k++) do_op(32'h8000_8000, 32'h8000_8000, 1'b0, 1'b1);
    check(acc == 64'h2_0000_0000, "R4 wide headroom", acc, 64'h2_0000_0000);
    check(!ovf, "R4 wide no flag", {63'h0, ovf}, 64'h0);
    check(q15 == 16'h7FFF, "R7 clamp high", {48'h0, q15}, 64'h7FFF);

    // R2 odd tap: zeroed high half of A ignores the high half of B
    do_clear();
    do_op(32'h0000_4000, 32'h7FFF_FFFE, 1'b0, 1'b1);
    check(acc == 64'hFFFF_FFFF_FFFF_8000, "R2 zero half", acc, 64'hFFFF_FFFF_FFFF_8000);
    check(q15 == 16'hFFFF, "R7 floor rounding", {48'h0, q15}, 64'hFFFF);
    // R3 equal products cancel in difference mode (R1 signed halves)
    do_op(32'h8000_8000, 32'h8000_8000, 1'b1, 1'b1);
    check(acc == 64'hFFFF_FFFF_FFFF_8000, "R3 cancel", acc, 64'hFFFF_FFFF_FFFF_8000);
    @(negedge clk);
    check(!valid, "R9 single-cycle valid", {63'h0, valid}, 64'h0);

    summary();
    $finish;
  end
endmodule